// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz tick-enable strobe into periodic interrupt requests. A 4-bit rate code selects a power-of-two period measured in ticks, and a separate enable input gates the whole generator. Whenever the selected period boundary is crossed, the block emits a one-cycle request together with the mask of status flag bits that the surrounding register file ORs into its interrupt status register.

A free-running tick counter is never cleared by a change of rate or enable. Events are therefore aligned to absolute multiples of the period on that counter: after a rate change, the first event falls on the next multiple of the new period. It does not wait a full period from the moment of the change. The rate code is non-linear: the two lowest non-zero codes alias to slow rates instead of the fastest ones.

Top module: `rate_irq_gen`

## Requirements
- R1: After reset, eventPulse is 0, setMask is 0 and the tick counter starts from zero, so the first event comes after exactly one period of ticks.
- R2: A rate code of 0 produces no events, whatever the ticks and the enable.
- R3: While periodicEnable is 0, no events are produced.
- R4: For codes 3 to 15 the period is 2^(code-1) ticks, so code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Code 1 gives a period of 128 ticks and code 2 gives a period of 256 ticks, the same periods as codes 8 and 9.
- R6: An event occurs on the tick that brings the total tick count since reset to a multiple of the current period. Rate or enable changes neither clear nor restart this count.
- R7: An event shows as eventPulse high for one clock cycle, starting the cycle after the tick that causes it. In that cycle setMask is 8'hC0 (bit 7 is the interrupt-request flag, bit 6 the periodic flag), and it is 8'h00 in every other cycle.
- R8: No event is produced in a cycle without a tick. A change of code or enable takes effect at the next tick and does not by itself cause an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle strobe at 32768 Hz |
| rateCode | input | 4 | Rate select code, 0 disables |
| periodicEnable | input | 1 | Gate for the periodic generator |
| eventPulse | output | 1 | One-cycle periodic interrupt request |
| setMask | output | 8 | Status bits to OR into the interrupt status register |

## Verification
The assertions assume that tickEn is a single-cycle strobe that is synchronous to clk, and that rateCode and periodicEnable change only between clock edges. They also assume that the fastest usable rate (code 3) never lets two events land on adjacent cycles. The stimulus drives every input on the falling edge. It keeps tickEn at one bit per cycle, changes the code only at random intervals, and spends long stretches on single codes, including the slowest code, so that the aliased and extreme periods are all reached.

// File: rtl/rig_pkg.sv
package rig_pkg;
  typedef struct packed {
    logic advance;
    logic fire;
  } strobe_t;

  localparam logic [7:0] FLAG_SET = 8'hC0;
endpackage

// File: rtl/rig_ctrl.sv
module rig_ctrl
  import rig_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              tickEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              periodicEnable,
  input  logic              lowZero,
  output logic [CNT_W-1:0]  lowMask,
  output strobe_t           strobes
);
  localparam logic [CODE_W-1:0] ALIAS_ONE = CODE_W'(8);
  localparam logic [CODE_W-1:0] ALIAS_TWO = CODE_W'(9);

  logic [CODE_W-1:0] effCode;
  logic [CODE_W-1:0] shiftAmt;
  logic              active;

  always_comb begin
    unique case (rateCode)
      CODE_W'(1): effCode = ALIAS_ONE;
      CODE_W'(2): effCode = ALIAS_TWO;
      default:    effCode = rateCode;
    endcase
    shiftAmt = effCode - CODE_W'(1);
    active   = periodicEnable && (rateCode != '0);
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign lowMask[i] = (int'(shiftAmt) > i);
  end

  always_comb begin
    strobes.advance = tickEn;
    strobes.fire    = tickEn && active && lowZero;
  end
endmodule

// File: rtl/rig_datapath.sv
module rig_datapath
  import rig_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [CNT_W-1:0] lowMask,
  output logic             lowZero,
  output logic             eventPulse,
  output logic [7:0]       setMask
);
  logic [CNT_W-1:0] tickCount;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    nextCount = tickCount + CNT_W'(1);
    lowZero   = ((nextCount & lowMask) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount  <= '0;
      eventPulse <= 1'b0;
      setMask    <= 8'h00;
    end else begin
      if (strobes.advance) tickCount <= nextCount;
      eventPulse <= strobes.fire;
      setMask    <= strobes.fire ? FLAG_SET : 8'h00;
    end
  end
endmodule

// File: rtl/rate_irq_gen.sv
module rate_irq_gen
  import rig_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              periodicEnable,
  output logic              eventPulse,
  output logic [7:0]        setMask
);
  strobe_t          strobes;
  logic [CNT_W-1:0] lowMask;
  logic             lowZero;

  rig_ctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_ctrl (
    .tickEn(tickEn),
    .rateCode(rateCode),
    .periodicEnable(periodicEnable),
    .lowZero(lowZero),
    .lowMask(lowMask),
    .strobes(strobes)
  );

  rig_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .lowMask(lowMask),
    .lowZero(lowZero),
    .eventPulse(eventPulse),
    .setMask(setMask)
  );
endmodule

// File: rtl/rig_checker.sv
module rig_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [CODE_W-1:0] rateCode,
  input logic              periodicEnable,
  input logic              eventPulse,
  input logic [7:0]        setMask
);
  assert_pulse_needs_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> $past(tickEn));

  assert_code_zero_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> ($past(rateCode) != '0));

  assert_gate_off_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> $past(periodicEnable));

  assert_flag_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != 8'h00) |-> (eventPulse && setMask == 8'hC0));

  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |=> !eventPulse);
endmodule

bind rate_irq_gen rig_checker #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/rate_irq_gen_test.sv
module rate_irq_gen_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       periodicEnable = 1'b0;
  logic       eventPulse;
  logic [7:0] setMask;

  int  checks = 0;
  int  errors = 0;
  int  ticksSeen = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rate_irq_gen uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateCode(rateCode),
    .periodicEnable(periodicEnable), .eventPulse(eventPulse), .setMask(setMask)
  );

  function automatic int periodOf(input logic [3:0] code);
    if (code == 4'd1) return 128;
    if (code == 4'd2) return 256;
    return 1 << (int'(code) - 1);
  endfunction

  function automatic bit expectEvent(input bit tick, input logic [3:0] code,
                                     input bit en, input int count);
    if (!tick || !en || code == 4'd0) return 1'b0;
    return ((count + 1) % periodOf(code)) == 0;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at t=%0t", tag, actual, expected, $time);
    end
  endtask

  task automatic step(input bit tick, input logic [3:0] code, input bit en, input string tag);
    bit exp;
    tickEn = tick;
    rateCode = code;
    periodicEnable = en;
    exp = expectEvent(tick, code, en, ticksSeen);
    if (tick) ticksSeen++;
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(eventPulse), int'(exp));
    check(exp ? "R7" : tag, int'(setMask), exp ? 32'hC0 : 0);
  endtask

  function automatic string tagFor(input bit tick, input logic [3:0] code, input bit en);
    if (code == 4'd0) return "R2";
    if (!en) return "R3";
    if (!tick) return "R8";
    if (code <= 4'd2) return "R5";
    return "R4";
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'(eventPulse), 0);
    check("R1", int'(setMask), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(eventPulse), 0);

    // R1: first event exactly one period (4 ticks) after reset
    for (int i = 0; i < 12; i++) step(1'b1, 4'd3, 1'b1, "R1");

    // R2: code zero silent
    for (int i = 0; i < 300; i++) step(1'b1, 4'd0, 1'b1, "R2");
    // R3: enable low silent
    for (int i = 0; i < 300; i++) step(1'b1, 4'd3, 1'b0, "R3");

    // R8: no tick, code toggling, no event
    for (int i = 0; i < 40; i++) step(1'b0, 4'(3 + (i % 4)), 1'b1, "R8");

    // R5: aliased low codes
    for (int i = 0; i < 600; i++) step(1'b1, 4'd1, 1'b1, "R5");
    for (int i = 0; i < 600; i++) step(1'b1, 4'd2, 1'b1, "R5");

    // R6: switch mid-period to a faster rate; next event on next multiple
    for (int i = 0; i < 21; i++) step(1'b1, 4'd6, 1'b1, "R6");
    for (int i = 0; i < 20; i++) step(1'b1, 4'd3, 1'b1, "R6");
    for (int i = 0; i < 5; i++) step(1'b1, 4'd6, 1'b0, "R6");
    for (int i = 0; i < 70; i++) step(1'b1, 4'd6, 1'b1, "R6");

    // Random mix
    begin
      logic [3:0] code = 4'd4;
      bit en = 1'b1;
      for (int i = 0; i < 15000; i++) begin
        bit tick = ($urandom % 4) != 0;
        if ($urandom % 200 == 0) code = 4'($urandom % 10);
        if ($urandom % 150 == 0) en = ($urandom % 8) != 0;
        step(tick, code, en, tagFor(tick, code, en));
      end
    end

    // R4: slowest rate, 16384 ticks
    for (int i = 0; i < 33000; i++) step(1'b1, 4'd15, 1'b1, "R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule